// File: doc/BRIEF.md
# Collision Backoff and Retry Controller

This block decides when a broadcast request frame may go out on a shared medium and how the transmitter responds when that frame collides. It holds a backoff window as a run of ones that grows from bit 0. The wait before each attempt is the low bits of a free-running counter masked by that window. When the window is empty, a fixed initial delay is used instead. When the window is already full, the transmitter is turned off and the block waits for a long timeout.

Each time the timeout expires, the request is issued again with a cleared window and the retry counter is advanced. Once the retry limit has been used up, the next expiry turns the transmitter and the receiver off for good and raises a failure flag. A received frame reloads the timeout with a shorter interval. The timeout counter advances on an external tick, and every count and delay is a parameter.

Top module: `backoff_retry_ctrl`

## Requirements
- R1: While rst_ni is low, tx_start_o, tx_enable_o, rx_enable_o, timeout_o and boot_failed_o are all 0. Within 3 clock cycles after reset release, a request is issued: tx_enable_o and rx_enable_o go to 1.
- R2: For the first attempt of a request, the window is empty. tx_start_o pulses for one cycle between INIT_DELAY and INIT_DELAY+3 cycles after tx_enable_o rises, and tx_enable_o is 1 whenever tx_start_o is 1.
- R3: A collision_i pulse during transmission adds one 1 at the low end of the window. Attempt number j of a request therefore waits with a window of j ones, and its tx_start_o follows the collision by at most 2^j+3 cycles.
- R4: A collision on an attempt made with a full window of MASK_W ones does not lead to another attempt. Exactly MASK_W attempts occur. tx_enable_o drops within 2 cycles and stays 0, with no tx_start_o, until the timeout expires.
- R5: On timeout expiry the request is re-issued: tx_enable_o rises again and the window is cleared, so the first attempt again uses the initial delay of R2.
- R6: An other_attn_i pulse during transmission restores the window to its value before the last growth. The next attempt uses the same window again, and MASK_W-1 further collisions are then needed to turn the transmitter off.
- R7: Issuing a request loads the timeout with LONG_LOAD. timeout_o pulses for one cycle LONG_LOAD ticks later, with a tolerance of one tick period, unless a frame arrives first.
- R8: Each frame_rx_i pulse reloads the timeout with SHORT_LOAD. While frames keep arriving faster than that, timeout_o stays 0. After the last frame, timeout_o pulses SHORT_LOAD ticks later.
- R9: After RETRY_LIMIT requests, the next expiry sets boot_failed_o to 1 permanently. tx_enable_o and rx_enable_o become 0, and tx_start_o and timeout_o stay 0 afterwards.
- R10: tx_done_i during transmission turns tx_enable_o off. No further tx_start_o occurs until the timeout re-issues the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timeout tick, one cycle per period |
| tx_done_i | input | 1 | Frame sent without incident |
| collision_i | input | 1 | Collision seen during transmission |
| other_attn_i | input | 1 | Transmission stopped for another reason |
| frame_rx_i | input | 1 | A good frame was received |
| tx_start_o | output | 1 | One-cycle pulse: begin sending the request frame |
| tx_enable_o | output | 1 | Transmitter enable |
| rx_enable_o | output | 1 | Receiver enable |
| timeout_o | output | 1 | One-cycle pulse on timeout expiry |
| boot_failed_o | output | 1 | Retry limit exhausted, sticky |

## Verification
A corrupted backoff window shows at the ports as the wrong number of attempts before tx_enable_o drops, or as a tx_start_o that comes later than the window allows. Either fault is visible within one collision sequence, a few tens of cycles. A window that is not cleared or restored shows on the attempt that follows a timeout or other-attention event, because the initial delay or the attempt count is then wrong. Timer and retry faults show as a timeout_o pulse outside its tick budget, or as boot_failed_o after the wrong number of tx_enable_o rises.

// File: rtl/bkr_pkg.sv
package bkr_pkg;
  typedef enum logic [2:0] {
    ST_PREP,
    ST_DECIDE,
    ST_WAIT,
    ST_TX,
    ST_IDLE,
    ST_FAIL
  } bkr_state_e;
endpackage

// File: rtl/bkr_mask.sv
module bkr_mask #(
  parameter int MASK_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              grow_i,
  input  logic              restore_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [MASK_W-1:0] next_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [MASK_W-1:0] mask_q, old_q;

  assign next_o  = {mask_q[MASK_W-2:0], 1'b1};
  assign mask_o  = mask_q;
  assign empty_o = (mask_q == '0);
  assign full_o  = mask_q[MASK_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      old_q  <= '0;
    end else if (clear_i) begin
      mask_q <= '0;
      old_q  <= '0;
    end else if (grow_i) begin
      old_q  <= mask_q;
      mask_q <= next_o;
    end else if (restore_i) begin
      mask_q <= old_q;
    end
  end

  AST_MASK_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_q & MASK_W'(mask_q + 1'b1)) == '0)); // R3

  AST_MASK_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !clear_i && !grow_i) |=> (mask_q == $past(old_q))); // R6
endmodule

// File: rtl/bkr_wait.sv
module bkr_wait #(
  parameter int MASK_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  output logic [MASK_W-1:0] rnd_o,
  output logic              zero_o
);
  logic [MASK_W-1:0] rnd_q;
  logic [CNT_W-1:0]  cnt_q;

  assign rnd_o  = rnd_q;
  assign zero_o = (cnt_q == '0);

  // free-running source sampled at an arbitrary phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rnd_q <= '0;
    else         rnd_q <= rnd_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  AST_WAIT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
endmodule

// File: rtl/bkr_timer.sv
module bkr_timer #(
  parameter int TMO_W      = 32,
  parameter int LONG_LOAD  = 347222,
  parameter int SHORT_LOAD = 69444
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_long_i,
  input  logic load_short_i,
  output logic expire_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             exp_q;
  logic             loading;

  assign loading  = load_long_i | load_short_i;
  assign expire_o = exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= !loading && tick_i && (cnt_q == TMO_W'(1));
      if (load_long_i)                 cnt_q <= TMO_W'(LONG_LOAD);
      else if (load_short_i)           cnt_q <= TMO_W'(SHORT_LOAD);
      else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_EXPIRE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(tick_i)); // R7

  AST_EXPIRE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o); // R7
endmodule

// File: rtl/bkr_retry.sv
module bkr_retry #(
  parameter int RETRY_LIMIT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output logic limit_o
);
  localparam int CW = $clog2(RETRY_LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign limit_o = (cnt_q == CW'(RETRY_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (inc_i && !limit_o) cnt_q <= cnt_q + 1'b1;
  end

  AST_RETRY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(RETRY_LIMIT)); // R9
endmodule

// File: rtl/backoff_retry_ctrl.sv
module backoff_retry_ctrl
  import bkr_pkg::*;
#(
  parameter int MASK_W      = 10,
  parameter int INIT_DELAY  = 50000,
  parameter int TMO_W       = 32,
  parameter int LONG_LOAD   = 347222,
  parameter int SHORT_LOAD  = 69444,
  parameter int RETRY_LIMIT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic tx_done_i,
  input  logic collision_i,
  input  logic other_attn_i,
  input  logic frame_rx_i,
  output logic tx_start_o,
  output logic tx_enable_o,
  output logic rx_enable_o,
  output logic timeout_o,
  output logic boot_failed_o
);
  localparam int IW    = $clog2(INIT_DELAY + 1);
  localparam int CNT_W = (IW > MASK_W) ? IW : MASK_W;

  bkr_state_e st_q, st_d;
  logic tx_en_q, tx_en_d, rx_en_q, rx_en_d, fail_q, fail_d, start_q, start_d;
  logic m_clear, m_grow, m_restore, m_empty, m_full;
  logic [MASK_W-1:0] m_mask, m_next, rnd;
  logic w_load, w_zero;
  logic [CNT_W-1:0] w_val;
  logic r_inc, r_limit;
  logic t_long, t_short, t_exp;

  bkr_mask #(.MASK_W(MASK_W)) u_mask (
    .clk_i, .rst_ni,
    .clear_i(m_clear), .grow_i(m_grow), .restore_i(m_restore),
    .mask_o(m_mask), .next_o(m_next), .empty_o(m_empty), .full_o(m_full)
  );

  bkr_wait #(.MASK_W(MASK_W), .CNT_W(CNT_W)) u_wait (
    .clk_i, .rst_ni,
    .load_i(w_load), .load_val_i(w_val), .rnd_o(rnd), .zero_o(w_zero)
  );

  bkr_timer #(.TMO_W(TMO_W), .LONG_LOAD(LONG_LOAD), .SHORT_LOAD(SHORT_LOAD)) u_timer (
    .clk_i, .rst_ni, .tick_i,
    .load_long_i(t_long), .load_short_i(t_short), .expire_o(t_exp)
  );

  bkr_retry #(.RETRY_LIMIT(RETRY_LIMIT)) u_retry (
    .clk_i, .rst_ni, .inc_i(r_inc), .limit_o(r_limit)
  );

  assign w_val   = m_empty ? CNT_W'(INIT_DELAY) : CNT_W'(rnd & m_next);
  assign t_short = frame_rx_i && (st_q != ST_FAIL) && (st_q != ST_PREP);

  always_comb begin
    st_d      = st_q;
    tx_en_d   = tx_en_q;
    rx_en_d   = rx_en_q;
    fail_d    = fail_q;
    start_d   = 1'b0;
    m_clear   = 1'b0;
    m_grow    = 1'b0;
    m_restore = 1'b0;
    w_load    = 1'b0;
    r_inc     = 1'b0;
    t_long    = 1'b0;
    unique case (st_q)
      ST_PREP: begin
        if (r_limit) begin
          st_d    = ST_FAIL;
          tx_en_d = 1'b0;
          rx_en_d = 1'b0;
          fail_d  = 1'b1;
        end else begin
          st_d    = ST_DECIDE;
          r_inc   = 1'b1;
          t_long  = 1'b1;
          m_clear = 1'b1;
          tx_en_d = 1'b1;
          rx_en_d = 1'b1;
        end
      end
      ST_DECIDE: begin
        if (m_full) begin
          st_d    = ST_IDLE;
          tx_en_d = 1'b0;
        end else begin
          st_d   = ST_WAIT;
          m_grow = 1'b1;
          w_load = 1'b1;
        end
      end
      ST_WAIT: begin
        if (w_zero) begin
          st_d    = ST_TX;
          start_d = 1'b1;
        end
      end
      ST_TX: begin
        if (collision_i) begin
          st_d = ST_DECIDE;
        end else if (other_attn_i) begin
          st_d      = ST_DECIDE;
          m_restore = 1'b1;
        end else if (tx_done_i) begin
          st_d    = ST_IDLE;
          tx_en_d = 1'b0;
        end
      end
      ST_IDLE: ;
      ST_FAIL: ;
      default: st_d = ST_FAIL;
    endcase
    // expiry re-issues the request from any live state
    if (t_exp && st_q != ST_FAIL && st_q != ST_PREP) begin
      st_d      = ST_PREP;
      start_d   = 1'b0;
      m_grow    = 1'b0;
      m_restore = 1'b0;
      w_load    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PREP;
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      fail_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tx_en_q <= tx_en_d;
      rx_en_q <= rx_en_d;
      fail_q  <= fail_d;
      start_q <= start_d;
    end
  end

  assign tx_start_o    = start_q;
  assign tx_enable_o   = tx_en_q;
  assign rx_enable_o   = rx_en_q;
  assign timeout_o     = t_exp;
  assign boot_failed_o = fail_q;

  AST_START_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> tx_enable_o); // R2

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o); // R2

  AST_FAIL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_failed_o |-> (!tx_enable_o && !rx_enable_o && !tx_start_o)); // R9

  AST_FAIL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_failed_o |=> boot_failed_o); // R9

  AST_FULL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DECIDE && m_full && !t_exp) |=> !tx_enable_o); // R4
endmodule

// File: tb/backoff_retry_ctrl_tb.sv
`timescale 1ns/1ps
module backoff_retry_ctrl_tb;
  localparam int MW    = 4;
  localparam int INIT  = 20;
  localparam int LONG  = 60;
  localparam int SHORT = 25;
  localparam int LIM   = 10;
  localparam int TPER  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_i = 1'b0, tx_done_i = 1'b0, collision_i = 1'b0, other_attn_i = 1'b0, frame_rx_i = 1'b0;
  logic tx_start_o, tx_enable_o, rx_enable_o, timeout_o, boot_failed_o;
  int errors = 0, checks = 0, tdiv = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv   = (tdiv + 1) % TPER;
    tick_i = (tdiv == 0);
  end

  backoff_retry_ctrl #(
    .MASK_W(MW), .INIT_DELAY(INIT), .TMO_W(16),
    .LONG_LOAD(LONG), .SHORT_LOAD(SHORT), .RETRY_LIMIT(LIM)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .tx_done_i(tx_done_i),
    .collision_i(collision_i), .other_attn_i(other_attn_i), .frame_rx_i(frame_rx_i),
    .tx_start_o(tx_start_o), .tx_enable_o(tx_enable_o), .rx_enable_o(rx_enable_o),
    .timeout_o(timeout_o), .boot_failed_o(boot_failed_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tx_done_i = 0; collision_i = 0; other_attn_i = 0; frame_rx_i = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_rise(input int limit, output int n);
    n = 0;
    while (n < limit && !tx_enable_o) begin
      @(negedge clk);
      n++;
    end
  endtask

  // kind: 1 start seen, 2 transmitter off, 0 nothing
  task automatic wait_event(input int limit, output int n, output int kind);
    n = 0; kind = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (tx_start_o) begin kind = 1; break; end
      if (!tx_enable_o) begin kind = 2; break; end
    end
  endtask

  task automatic pulse_col();
    collision_i = 1'b1; @(negedge clk); collision_i = 1'b0;
  endtask

  task automatic pulse_done();
    tx_done_i = 1'b1; @(negedge clk); tx_done_i = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tx_start_o, "R1 start in reset", tx_start_o, 0);
    chk(!tx_enable_o && !rx_enable_o, "R1 enables in reset", tx_enable_o, 0);
    chk(!timeout_o, "R1 timeout in reset", timeout_o, 0);
    chk(!boot_failed_o, "R1 failed in reset", boot_failed_o, 0);
    do_reset();
    wait_rise(5, n);
    chk(tx_enable_o && rx_enable_o && n <= 3, "R1 request issued", n, 3);
  endtask

  task automatic t_backoff();
    int n, kind, att;
    do_reset();
    wait_rise(5, n);
    wait_event(60, n, kind);
    chk(kind == 1 && n >= INIT && n <= INIT + 3, "R2 initial delay", n, INIT + 2);
    att = 1;
    forever begin
      pulse_col();
      wait_event(60, n, kind);
      if (kind != 1) break;
      att++;
      chk(n <= (1 << att) + 3, "R3 backoff window bound", n, (1 << att) + 3);
    end
    chk(kind == 2 && n <= 2, "R4 off after full window", n, 1);
    chk(att == MW, "R4 attempt count", att, MW);
    n = 0;
    repeat (100) begin
      @(negedge clk);
      if (tx_start_o || tx_enable_o) n++;
    end
    chk(n == 0, "R4 silent until timeout", n, 0);
    wait_rise(400, n);
    chk(tx_enable_o == 1'b1, "R5 request re-issued", tx_enable_o, 1);
    wait_event(60, n, kind);
    chk(kind == 1 && n >= INIT && n <= INIT + 3, "R5 cleared window delay", n, INIT + 2);
  endtask

  task automatic t_other();
    int n, kind, att;
    do_reset();
    wait_rise(5, n);
    wait_event(60, n, kind);
    pulse_col();
    wait_event(60, n, kind);
    chk(kind == 1, "R3 second attempt", kind, 1);
    other_attn_i = 1'b1; @(negedge clk); other_attn_i = 1'b0;
    wait_event(60, n, kind);
    chk(kind == 1 && n <= 7, "R6 restored window delay", n, 7);
    att = 1;
    forever begin
      pulse_col();
      wait_event(60, n, kind);
      if (kind != 1) break;
      att++;
    end
    chk(att == MW - 1, "R6 attempts after restore", att, MW - 1);
  endtask

  task automatic t_timeout();
    int n, starts, hi;
    bit seen;
    do_reset();
    wait_rise(5, n);
    n = 0; starts = 0; hi = 0; seen = 0;
    while (n < 1000 && !seen) begin
      @(negedge clk);
      n++;
      tx_done_i = 1'b0;
      if (timeout_o) seen = 1;
      if (tx_start_o) begin starts++; tx_done_i = 1'b1; end
      if (starts > 0 && n > INIT + 10 && tx_enable_o) hi++;
    end
    tx_done_i = 1'b0;
    chk(seen && n >= LONG*TPER - 5 && n <= LONG*TPER + 5, "R7 long timeout", n, LONG*TPER);
    chk(starts == 1, "R10 single start after done", starts, 1);
    chk(hi == 0, "R10 transmitter off after done", hi, 0);
  endtask

  task automatic t_frame();
    int n, kind, tmo;
    bit seen;
    do_reset();
    wait_rise(5, n);
    wait_event(60, n, kind);
    pulse_done();
    tmo = 0;
    repeat (8) begin
      repeat (50) begin
        @(negedge clk);
        if (timeout_o || tx_enable_o) tmo++;
      end
      frame_rx_i = 1'b1; @(negedge clk); frame_rx_i = 1'b0;
    end
    chk(tmo == 0, "R8 no timeout while frames arrive", tmo, 0);
    n = 1; seen = 0;
    while (n < 600 && !seen) begin
      if (timeout_o) seen = 1;
      else begin @(negedge clk); n++; end
    end
    chk(seen && n >= SHORT*TPER - 5 && n <= SHORT*TPER + 5, "R8 short timeout", n, SHORT*TPER);
  endtask

  task automatic t_fail();
    int n, rises, bad;
    bit prev;
    do_reset();
    rises = 0; prev = 0; n = 0;
    while (n < 40000 && !boot_failed_o) begin
      @(negedge clk);
      n++;
      tx_done_i = 1'b0;
      if (tx_enable_o && !prev) rises++;
      prev = tx_enable_o;
      if (tx_start_o) tx_done_i = 1'b1;
    end
    tx_done_i = 1'b0;
    chk(boot_failed_o == 1'b1, "R9 failure declared", boot_failed_o, 1);
    chk(rises == LIM, "R9 request count", rises, LIM);
    chk(!tx_enable_o && !rx_enable_o, "R9 enables off", rx_enable_o, 0);
    bad = 0;
    repeat (600) begin
      @(negedge clk);
      if (tx_start_o || timeout_o || tx_enable_o || rx_enable_o || !boot_failed_o) bad++;
    end
    chk(bad == 0, "R9 failure sticky and quiet", bad, 0);
  endtask

  initial begin
    t_reset();
    t_backoff();
    t_other();
    t_timeout();
    t_frame();
    t_fail();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule